// File: doc/BRIEF.md
# Relative Branch Resolver

This block decides whether a relative branch instruction of an 8-bit processor is taken and where it goes. It is given the branch opcode, the status flag byte, the address of the branch instruction, a signed displacement byte and, for the memory bit-test branches, the zero-page byte that was read. It reports whether the opcode is a branch at all, whether the branch is taken, the 16-bit address where execution continues, and whether a taken branch lands in a different 256-byte page from the instruction that follows the branch, so that the sequencer can add its extra cycle.

Three kinds of branch are resolved: the eight branches on a single status flag, one branch that is always taken, and sixteen three-byte branches that test one bit of a memory byte, the bit number being carried in the opcode. A request is presented with `in_valid` for one cycle. With the default `REG_OUT = 1` the result is registered and appears with `out_valid` one clock later. With `REG_OUT = 0` the result follows the inputs combinationally. Operand fetching and instruction sequencing stay with the rest of the processor.

Top module: `branch_resolver`

## Requirements
- R1: The flag branches are taken under these conditions, where the flag byte holds negative at bit 7, overflow at bit 6, zero at bit 1 and carry at bit 0: 10h when negative is 0, 30h when negative is 1, 50h when overflow is 0, 70h when overflow is 1, 90h when carry is 0, B0h when carry is 1, D0h when zero is 0, F0h when zero is 1.
- R2: Opcode 80h is always taken, whatever the flags.
- R3: Opcode 0Fh + 10h*b (b = 0..7) is taken when bit b of the memory byte is 0.
- R4: Opcode 8Fh + 10h*b (b = 0..7) is taken when bit b of the memory byte is 1.
- R5: A taken branch's target is the next address plus the sign-extended displacement, modulo 2^16. The next address is the branch address plus 2 for the flag branches and 80h, and plus 3 for the bit-test branches.
- R6: A branch that is not taken reports the next address as its target.
- R7: The page-cross output is 1 exactly when the branch is taken and bits 15:8 of the target differ from bits 15:8 of the next address.
- R8: Any other opcode reports is-branch 0, taken 0, page-cross 0, and a target equal to the branch address plus 2.
- R9: With registered output, the result appears with out_valid in the cycle after in_valid, requests may come back to back, out_valid is 0 in cycles that follow no request, and reset clears out_valid, taken and page-cross.
- R10: Flag byte bits 5, 4, 3 and 2 never change a result, and the memory byte has no effect on the flag branches or 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Branch opcode |
| flags | input | 8 | Status flag byte |
| branch_pc | input | 16 | Address of the branch instruction |
| disp | input | 8 | Signed displacement |
| mem_byte | input | 8 | Zero-page byte tested by bit-test branches |
| out_valid | output | 1 | Result strobe |
| is_branch | output | 1 | Opcode is a relative branch |
| taken | output | 1 | Branch taken |
| target | output | 16 | Address where execution continues |
| page_cross | output | 1 | Taken target lies in another page |

## Verification
A wrong flag or bit selection in the decoder shows up as an inverted `taken` for one of the condition opcodes, and a wrong instruction length shows up as a target off by one. Both appear on the same `out_valid` beat as the request that exercised them. The bench therefore sweeps every flag opcode with the flag both ways, every bit position for both bit-test polarities, and displacements at +127, -128 and 0. It also aims branches across page boundaries and across the top of the address space, so that a faulty page comparison is visible in the very next result.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;

   typedef enum logic [1:0] {
      KIND_NONE    = 2'd0,
      KIND_FLAG    = 2'd1,
      KIND_ALWAYS  = 2'd2,
      KIND_BITTEST = 2'd3
   } br_kind_e;

   localparam int unsigned POS_NEG   = 7;
   localparam int unsigned POS_OVF   = 6;
   localparam int unsigned POS_ZERO  = 1;
   localparam int unsigned POS_CARRY = 0;

   localparam logic [7:0] OPC_ALWAYS = 8'h80;

   localparam int unsigned LEN_SHORT = 2;
   localparam int unsigned LEN_LONG  = 3;

endpackage

// File: rtl/branch_resolver_decode.sv
module branch_resolver_decode
   import branch_resolver_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic [7:0]       opcode,
   output br_kind_e         kind,
   output logic [IDX_W-1:0] sel,
   output logic             want,
   output logic             long_form
);

   always_comb begin
      kind      = KIND_NONE;
      sel       = '0;
      want      = 1'b0;
      long_form = 1'b0;
      if (opcode == OPC_ALWAYS) begin
         kind = KIND_ALWAYS;
      end else if (opcode[4:0] == 5'b10000) begin
         kind = KIND_FLAG;
         want = opcode[5];
         unique case (opcode[7:6])
            2'b00:   sel = IDX_W'(POS_NEG);
            2'b01:   sel = IDX_W'(POS_OVF);
            2'b10:   sel = IDX_W'(POS_CARRY);
            default: sel = IDX_W'(POS_ZERO);
         endcase
      end else if (opcode[3:0] == 4'hF) begin
         kind      = KIND_BITTEST;
         want      = opcode[7];
         sel       = IDX_W'(opcode[6:4]);
         long_form = 1'b1;
      end
   end

endmodule

// File: rtl/branch_resolver_cond.sv
module branch_resolver_cond
   import branch_resolver_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  br_kind_e          kind,
   input  logic [IDX_W-1:0]  sel,
   input  logic              want,
   input  logic [DATA_W-1:0] flags,
   input  logic [DATA_W-1:0] mem_byte,
   output logic              taken
);

   logic flag_bit;
   logic mem_bit;

   assign flag_bit = flags[sel];
   assign mem_bit  = mem_byte[sel];

   always_comb begin
      unique case (kind)
         KIND_ALWAYS:  taken = 1'b1;
         KIND_FLAG:    taken = (flag_bit == want);
         KIND_BITTEST: taken = (mem_bit == want);
         default:      taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/branch_resolver_target.sv
module branch_resolver_target
   import branch_resolver_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DISP_W = 8,
   parameter int unsigned PAGE_W = 8
) (
   input  logic [ADDR_W-1:0] branch_pc,
   input  logic              long_form,
   input  logic [DISP_W-1:0] disp,
   input  logic              taken,
   output logic [ADDR_W-1:0] next_addr,
   output logic [ADDR_W-1:0] target,
   output logic              page_cross
);

   localparam int unsigned EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] jump_addr;

   assign next_addr  = branch_pc + (long_form ? ADDR_W'(LEN_LONG) : ADDR_W'(LEN_SHORT));
   assign disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign jump_addr  = next_addr + disp_ext;
   assign target     = taken ? jump_addr : next_addr;
   assign page_cross = taken &&
                       (jump_addr[ADDR_W-1:PAGE_W] != next_addr[ADDR_W-1:PAGE_W]);

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
   import branch_resolver_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DISP_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PAGE_W  = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] flags,
   input  logic [ADDR_W-1:0] branch_pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [DATA_W-1:0] mem_byte,
   output logic              out_valid,
   output logic              is_branch,
   output logic              taken,
   output logic [ADDR_W-1:0] target,
   output logic              page_cross
);

   localparam int unsigned IDX_W = $clog2(DATA_W);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("branch_resolver: DATA_W must be 8, the opcode carries a 3-bit index");
   end
   if (DISP_W >= ADDR_W) begin : g_bad_disp_w
      $error("branch_resolver: DISP_W must be narrower than ADDR_W");
   end
   if (PAGE_W == 0 || PAGE_W >= ADDR_W) begin : g_bad_page_w
      $error("branch_resolver: PAGE_W must lie between 1 and ADDR_W-1");
   end

   br_kind_e          kind;
   logic [IDX_W-1:0]  sel;
   logic              want;
   logic              long_form;
   logic              cond_taken;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] comb_target;
   logic              comb_cross;
   logic              comb_is_branch;

   branch_resolver_decode #(.DATA_W(DATA_W)) i_decode (
      .opcode    (opcode),
      .kind      (kind),
      .sel       (sel),
      .want      (want),
      .long_form (long_form)
   );

   branch_resolver_cond #(.DATA_W(DATA_W)) i_cond (
      .kind     (kind),
      .sel      (sel),
      .want     (want),
      .flags    (flags),
      .mem_byte (mem_byte),
      .taken    (cond_taken)
   );

   branch_resolver_target #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .PAGE_W (PAGE_W)
   ) i_target (
      .branch_pc  (branch_pc),
      .long_form  (long_form),
      .disp       (disp),
      .taken      (cond_taken),
      .next_addr  (next_addr),
      .target     (comb_target),
      .page_cross (comb_cross)
   );

   assign comb_is_branch = (kind != KIND_NONE);

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            is_branch  <= 1'b0;
            taken      <= 1'b0;
            target     <= '0;
            page_cross <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               is_branch  <= comb_is_branch;
               taken      <= cond_taken;
               target     <= comb_target;
               page_cross <= comb_cross;
            end
         end
      end

      // R9: a request yields a result on the next cycle
      assert_result_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R2: the unconditional opcode always resolves taken
      assert_always_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == OPC_ALWAYS) |=> taken);

      // R6: an untaken request hands back the sequential address
      assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !cond_taken) |=> (target == $past(next_addr)));
   end else begin : g_comb_out
      assign out_valid  = in_valid;
      assign is_branch  = comb_is_branch;
      assign taken      = cond_taken;
      assign target     = comb_target;
      assign page_cross = comb_cross;
   end

   // R7: a page crossing is only ever reported for a taken branch
   assert_cross_needs_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && page_cross) |-> taken);

   // R8: opcodes outside the branch set resolve quietly
   assert_nonbranch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !is_branch) |-> (!taken && !page_cross));

endmodule

// File: tb/test_branch_resolver.sv
module test_branch_resolver;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = 8'hEA;
   logic [7:0]  flags = 8'h00;
   logic [15:0] branch_pc = 16'h0000;
   logic [7:0]  disp = 8'h00;
   logic [7:0]  mem_byte = 8'h00;
   logic        out_valid;
   logic        is_branch;
   logic        taken;
   logic [15:0] target;
   logic        page_cross;

   always #10 clk = ~clk;

   branch_resolver i_branch_resolver (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .opcode     (opcode),
      .flags      (flags),
      .branch_pc  (branch_pc),
      .disp       (disp),
      .mem_byte   (mem_byte),
      .out_valid  (out_valid),
      .is_branch  (is_branch),
      .taken      (taken),
      .target     (target),
      .page_cross (page_cross)
   );

   typedef struct packed {
      logic        isbr;
      logic        tk;
      logic        cr;
      logic [15:0] tgt;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   bit    finished = 1'b0;

   function automatic exp_t model(input logic [7:0] op, input logic [7:0] f,
                                  input logic [15:0] pc, input logic [7:0] d,
                                  input logic [7:0] mb);
      exp_t        e;
      logic [15:0] nxt;
      int          len;
      e.isbr = 1'b1;
      e.tk   = 1'b0;
      len    = 2;
      case (op)
         8'h10: e.tk = ~f[7];
         8'h30: e.tk =  f[7];
         8'h50: e.tk = ~f[6];
         8'h70: e.tk =  f[6];
         8'h90: e.tk = ~f[0];
         8'hB0: e.tk =  f[0];
         8'hD0: e.tk = ~f[1];
         8'hF0: e.tk =  f[1];
         8'h80: e.tk = 1'b1;
         default: begin
            e.isbr = 1'b0;
            for (int b = 0; b < 8; b++) begin
               if (op == 8'(8'h0F + 16 * b)) begin
                  e.isbr = 1'b1; len = 3; e.tk = ~mb[b];
               end
               if (op == 8'(8'h8F + 16 * b)) begin
                  e.isbr = 1'b1; len = 3; e.tk = mb[b];
               end
            end
         end
      endcase
      nxt   = pc + 16'(len);
      e.tgt = e.tk ? nxt + {{8{d[7]}}, d} : nxt;
      e.cr  = e.tk && (e.tgt[15:8] != nxt[15:8]);
      return e;
   endfunction

   task automatic send(input logic [7:0] op, input logic [7:0] f,
                       input logic [15:0] pc, input logic [7:0] d,
                       input logic [7:0] mb, input string tag);
      @(negedge clk);
      opcode    = op;
      flags     = f;
      branch_pc = pc;
      disp      = d;
      mem_byte  = mb;
      in_valid  = 1'b1;
      exp_q.push_back(model(op, f, pc, d, mb));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic check_bit(input logic got, input logic want, input string what);
      n_checks++;
      if (got !== want) begin
         n_fails++;
         $display("FAIL %s: got %0b expected %0b", what, got, want);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t  e;
         string t;
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fails++;
            $display("FAIL R9: result with no pending request, got taken=%0b target=%h expected none",
                     taken, target);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (is_branch !== e.isbr || taken !== e.tk || target !== e.tgt || page_cross !== e.cr) begin
               n_fails++;
               $display("FAIL %s: got isbr=%0b taken=%0b target=%h cross=%0b expected isbr=%0b taken=%0b target=%h cross=%0b",
                        t, is_branch, taken, target, page_cross, e.isbr, e.tk, e.tgt, e.cr);
            end
         end
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got no completion expected completion");
         summary();
         $finish;
      end
   end

   localparam logic [7:0] FLAG_OPS [8] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check_bit(out_valid, 1'b0, "R9 reset out_valid");
      check_bit(taken, 1'b0, "R9 reset taken");
      check_bit(page_cross, 1'b0, "R9 reset page_cross");
      rst_n = 1'b1;
      idle(2);
      check_bit(out_valid, 1'b0, "R9 idle out_valid");

      // R1: every flag branch with all flags clear, then all set (back to back)
      foreach (FLAG_OPS[i]) send(FLAG_OPS[i], 8'h00, 16'h1200, 8'h10, 8'h00, "R1");
      foreach (FLAG_OPS[i]) send(FLAG_OPS[i], 8'hC3, 16'h1200, 8'hF0, 8'h00, "R1");
      // R1: one flag at a time
      send(8'h30, 8'h80, 16'h2000, 8'h05, 8'h00, "R1");
      send(8'h70, 8'h40, 16'h2000, 8'h05, 8'h00, "R1");
      send(8'hF0, 8'h02, 16'h2000, 8'h05, 8'h00, "R1");
      send(8'hB0, 8'h01, 16'h2000, 8'h05, 8'h00, "R1");
      send(8'h10, 8'h7F, 16'h2000, 8'h05, 8'h00, "R1");
      send(8'hD0, 8'hFD, 16'h2000, 8'h05, 8'h00, "R1");
      idle(1);

      // R10: bits 5..2 set and memory byte noise do not matter
      foreach (FLAG_OPS[i]) send(FLAG_OPS[i], 8'h3C, 16'h3000, 8'h20, 8'hFF, "R10");
      send(8'h80, 8'h3C, 16'h3000, 8'h20, 8'hA5, "R10");

      // R2: always taken under any flags
      send(8'h80, 8'h00, 16'h4000, 8'h7F, 8'h00, "R2");
      send(8'h80, 8'hFF, 16'h4000, 8'h80, 8'h00, "R2");

      // R3 / R4: every bit position, both polarities, both bit values
      for (int b = 0; b < 8; b++) begin
         send(8'(8'h0F + 16 * b), 8'h00, 16'h5000, 8'h08, 8'(~(8'h01 << b)), "R3");
         send(8'(8'h0F + 16 * b), 8'hFF, 16'h5000, 8'h08, 8'(8'h01 << b), "R3");
         send(8'(8'h8F + 16 * b), 8'h00, 16'h5000, 8'h08, 8'(8'h01 << b), "R4");
         send(8'(8'h8F + 16 * b), 8'hFF, 16'h5000, 8'h08, 8'(~(8'h01 << b)), "R4");
      end
      idle(2);

      // R5: displacement extremes and three-byte length
      send(8'h80, 8'h00, 16'h6010, 8'h7F, 8'h00, "R5");
      send(8'h80, 8'h00, 16'h6090, 8'h80, 8'h00, "R5");
      send(8'h80, 8'h00, 16'h6010, 8'h00, 8'h00, "R5");
      send(8'h8F, 8'h00, 16'h6010, 8'hFD, 8'h01, "R5");
      send(8'h80, 8'h00, 16'hFFF0, 8'h20, 8'h00, "R5");
      send(8'h80, 8'h00, 16'h0004, 8'hF0, 8'h00, "R5");

      // R6: untaken falls through, 2 or 3 bytes
      send(8'hF0, 8'h00, 16'h70FE, 8'h40, 8'h00, "R6");
      send(8'h0F, 8'h00, 16'h70FD, 8'h40, 8'hFF, "R6");
      send(8'hB0, 8'h00, 16'hFFFF, 8'h40, 8'h00, "R6");

      // R7: page crossing forward, backward, and at the last byte of a page
      send(8'h80, 8'h00, 16'h80F0, 8'h20, 8'h00, "R7");
      send(8'h80, 8'h00, 16'h8002, 8'hF0, 8'h00, "R7");
      send(8'h80, 8'h00, 16'h80FC, 8'h01, 8'h00, "R7");
      send(8'h80, 8'h00, 16'h80FC, 8'h02, 8'h00, "R7");
      send(8'h80, 8'h00, 16'h80FE, 8'h00, 8'h00, "R7");
      send(8'h90, 8'h01, 16'h80F0, 8'h7F, 8'h00, "R7");
      send(8'h8F, 8'h00, 16'h80FD, 8'hFF, 8'h01, "R7");

      // R8: non-branch opcodes
      send(8'hEA, 8'hFF, 16'h9000, 8'h80, 8'hFF, "R8");
      send(8'h4C, 8'h00, 16'h9000, 8'h7F, 8'h00, "R8");
      send(8'h00, 8'hC3, 16'h90FE, 8'h10, 8'h00, "R8");
      send(8'h87, 8'h00, 16'h9000, 8'h10, 8'hFF, "R8");
      send(8'h07, 8'h00, 16'h9000, 8'h10, 8'h00, "R8");
      send(8'h20, 8'h00, 16'hFFFF, 8'h10, 8'h00, "R8");
      idle(3);

      // R9: queue drained and output quiet after the last request
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fails++;
         $display("FAIL R9: got %0d pending results expected 0", exp_q.size());
      end
      check_bit(out_valid, 1'b0, "R9 quiet out_valid");

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule